// File: doc/BRIEF.md
# Fractional Oversampling Baud Rate Generator

This block derives the timing strobes a UART needs from a single input clock. Software writes a fixed-point divisor, made of an integer mantissa and a small fraction, together with a mode bit that picks 16x or 8x oversampling. The block then emits a one-cycle oversample strobe at an average spacing of exactly (mantissa + fraction) input clocks. It also emits a bit strobe on the last oversample strobe of every group of 16 (or 8) strobes. The fraction is spread over the group: each oversample period lasts either the mantissa or the mantissa plus one clock, as a running fractional accumulator decides.

The bit rate is the input clock divided by `8 * (2 - mode) * divisor`. At a 32 MHz clock in 8x mode, a divisor of 1 gives 4 Mbit/s and a divisor of 2 gives 2 Mbit/s. At 24 MHz, a divisor of 1 gives 3 Mbit/s. The block also reports the stored divisor, the whole number of input clocks per bit, and a flag for the illegal zero mantissa.

The prescaler is a three-state machine:
- `ST_HALT` is the idle state, held while the mantissa is zero.
- `ST_BASE` counts the mantissa clocks of a period.
- `ST_EXTRA` adds the one dithering clock to a period.

The transitions are:
- load-with-zero goes to `ST_HALT`.
- load-with-nonzero goes to `ST_BASE`.
- base-done-no-carry stays in `ST_BASE` and gives a strobe.
- base-done-carry goes to `ST_EXTRA`.
- extra-done returns to `ST_BASE` and gives a strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `os_tick` and `bit_tick` are 0, `div_bad` is 1, and `div_rd` and `ratio` are 0. No strobe appears until a divisor is written.
- R2: A write (`wr_en` high at a clock edge) stores `wr_div` and `wr_os8`. From the next cycle, `div_rd` shows the stored divisor: mantissa in bits [15:4], fraction in bits [3:0]. When `wr_os8`=1, bit 3 is stored and read as 0.
- R3: While the stored mantissa is zero, `div_bad` is 1 and `os_tick` never asserts.
- R4: With fraction 0, `os_tick` is a one-cycle pulse every M clocks. The first pulse comes in the M-th cycle after the write edge.
- R5: The effective fraction is F (16x, 4 bits) or F[2:0] (8x). The modulus is 16 or 8. An accumulator starts at 0 on a write. Each period lasts M+1 clocks if accumulator+F reaches the modulus, and M clocks otherwise. At each strobe the accumulator becomes (accumulator+F) mod modulus.
- R6: `bit_tick` asserts only together with `os_tick`, on the 16th (16x) or 8th (8x) strobe of each group, counted from the write.
- R7: A write restarts the period counter, the accumulator and the group count. The first strobe after a write arrives after exactly the first period length, whatever the phase before the write.
- R8: `ratio` equals 16*M+F in 16x mode and 8*M+F[2:0] in 8x mode.
- R9: In 8x mode, a mantissa of 1 with fraction 0 gives `bit_tick` every 8 clocks, and a mantissa of 2 gives it every 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (peripheral) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Divisor register write strobe |
| wr_div | input | 16 | Divisor to write: mantissa [15:4], fraction [3:0] |
| wr_os8 | input | 1 | Oversampling mode written with the divisor: 1 = 8x, 0 = 16x |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle bit strobe, on the last strobe of each group |
| div_bad | output | 1 | Stored mantissa is zero; generation halted |
| div_rd | output | 16 | Stored divisor readback |
| ratio | output | 16 | Input clocks per bit |

## Verification
A wrong accumulator value or a wrong carry decision makes one oversample period one clock too long or too short. This shows at `os_tick` in the very cycle the period ends, and it drifts every later strobe. A stale group count moves `bit_tick` away from every 16th or 8th strobe, so the error is visible within one bit time. For each divisor, the bench compares both strobes cycle by cycle over three bit times against a model built from the period rule alone. A failure to restart on a write shows as a wrong distance from the write to the first strobe.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_BASE  = 2'd1,
        ST_EXTRA = 2'd2
    } pre_state_t;
endpackage

// File: rtl/fbg_div_reg.sv
module fbg_div_reg #(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4,
    localparam int DIV_W = MANT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_os8,
    output logic [DIV_W-1:0] div_q,
    output logic             os8_q,
    output logic             mant_zero,
    output logic [DIV_W-1:0] ratio
);
    logic [DIV_W-1:0] div_masked;

    // in 8x mode the fraction MSB is held at zero
    always_comb begin
        div_masked = wr_div;
        if (wr_os8) div_masked[FRAC_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            os8_q <= 1'b0;
        end else if (wr_en) begin
            div_q <= div_masked;
            os8_q <= wr_os8;
        end
    end

    assign mant_zero = (div_q[DIV_W-1:FRAC_W] == '0);
    assign ratio = os8_q ? {1'b0, div_q[DIV_W-1:FRAC_W], div_q[FRAC_W-2:0]} : div_q;
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler
    import fbg_pkg::*;
#(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_zero,
    input  logic [MANT_W-1:0] mant,
    input  logic [FRAC_W-1:0] frac,
    input  logic              os8,
    output logic              os_tick
);
    pre_state_t        state_q, state_d;
    logic [MANT_W-1:0] cnt_q;
    logic [FRAC_W-1:0] acc_q, acc_nxt;
    logic [FRAC_W:0]   sum;
    logic              carry, cnt_last;

    assign sum      = {1'b0, acc_q} + {1'b0, frac};
    assign carry    = os8 ? sum[FRAC_W-1] : sum[FRAC_W];
    assign acc_nxt  = os8 ? {1'b0, sum[FRAC_W-2:0]} : sum[FRAC_W-1:0];
    assign cnt_last = (cnt_q == mant - MANT_W'(1));

    // next state and strobe
    always_comb begin
        state_d = state_q;
        os_tick = 1'b0;
        unique case (state_q)
            ST_HALT: state_d = ST_HALT;
            ST_BASE: begin
                if (cnt_last) begin
                    if (carry) state_d = ST_EXTRA;
                    else       os_tick = 1'b1;
                end
            end
            ST_EXTRA: begin
                os_tick = 1'b1;
                state_d = ST_BASE;
            end
            default: state_d = ST_HALT;
        endcase
        if (load) state_d = load_zero ? ST_HALT : ST_BASE;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else begin
                if (state_q == ST_BASE) cnt_q <= cnt_last ? '0 : cnt_q + MANT_W'(1);
                if (os_tick) acc_q <= acc_nxt;
            end
        end
    end
endmodule

// File: rtl/fbg_group_cnt.sv
module fbg_group_cnt #(
    parameter int GRP_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic os8,
    input  logic os_tick,
    output logic bit_tick
);
    logic [GRP_W-1:0] grp_q;
    logic [GRP_W-1:0] grp_last;

    assign grp_last = os8 ? {1'b0, {(GRP_W-1){1'b1}}} : {GRP_W{1'b1}};
    assign bit_tick = os_tick && (grp_q == grp_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       grp_q <= '0;
        else if (load)    grp_q <= '0;
        else if (os_tick) grp_q <= bit_tick ? '0 : grp_q + GRP_W'(1);
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4,
    localparam int DIV_W = MANT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_os8,
    output logic             os_tick,
    output logic             bit_tick,
    output logic             div_bad,
    output logic [DIV_W-1:0] div_rd,
    output logic [DIV_W-1:0] ratio
);
    logic             os8_q;
    logic             load_zero;

    assign load_zero = (wr_div[DIV_W-1:FRAC_W] == '0);

    fbg_div_reg #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_div    (wr_div),
        .wr_os8    (wr_os8),
        .div_q     (div_rd),
        .os8_q     (os8_q),
        .mant_zero (div_bad),
        .ratio     (ratio)
    );

    fbg_prescaler #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_en),
        .load_zero (load_zero),
        .mant      (div_rd[DIV_W-1:FRAC_W]),
        .frac      (div_rd[FRAC_W-1:0]),
        .os8       (os8_q),
        .os_tick   (os_tick)
    );

    fbg_group_cnt #(.GRP_W(FRAC_W)) grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .os8      (os8_q),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4,
    localparam int DIV_W = MANT_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_os8,
    input logic             os_tick,
    input logic             bit_tick,
    input logic             div_bad,
    input logic [DIV_W-1:0] div_rd,
    input logic [DIV_W-1:0] ratio
);
    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        div_bad |-> !os_tick); // R3

    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R6

    AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && !wr_en && (div_rd[DIV_W-1:FRAC_W] > MANT_W'(1))) |=> !os_tick); // R4

    AST_FRAC_MSB_8X: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_os8)) |-> !div_rd[FRAC_W-1]); // R2

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        !div_bad |-> (ratio >= DIV_W'(8))); // R8

    AST_RESTART_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !bit_tick); // R7
endmodule

bind frac_baud_gen fbg_checker #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_os8   (wr_os8),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .div_bad  (div_bad),
    .div_rd   (div_rd),
    .ratio    (ratio)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_div = '0;
    logic        wr_os8 = 1'b0;
    logic        os_tick, bit_tick, div_bad;
    logic [15:0] div_rd, ratio;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div), .wr_os8(wr_os8),
        .os_tick(os_tick), .bit_tick(bit_tick), .div_bad(div_bad),
        .div_rd(div_rd), .ratio(ratio)
    );

    // {os8, divisor written, expected readback, expected clocks per bit}
    localparam logic [48:0] VEC [8] = '{
        {1'b0, 16'h0030, 16'h0030, 16'd48},
        {1'b0, 16'h0025, 16'h0025, 16'd37},
        {1'b1, 16'h0010, 16'h0010, 16'd8},
        {1'b1, 16'h0020, 16'h0020, 16'd16},
        {1'b1, 16'h0033, 16'h0033, 16'd27},
        {1'b1, 16'h001F, 16'h0017, 16'd15},
        {1'b0, 16'h001F, 16'h001F, 16'd31},
        {1'b0, 16'h0058, 16'h0058, 16'd88}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // returns at the first negedge after the write edge
    task automatic do_write(input logic [15:0] d, input logic m8);
        @(negedge clk);
        wr_en = 1'b1; wr_div = d; wr_os8 = m8;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R4 R5 R6: cycle-accurate comparison against the period rule
    task automatic run_seq(input logic m8, input logic [15:0] d, input logic [15:0] exp_rd,
                           input logic [15:0] exp_ratio, input int n);
        int m, f, md, acc, c, g, len, errs;
        logic eo, eb;
        do_write(d, m8);
        chk(32'(div_rd), 32'(exp_rd), "R2 readback");
        chk(32'(ratio), 32'(exp_ratio), "R8 ratio");
        m = int'(d[15:4]);
        md = m8 ? 8 : 16;
        f = m8 ? int'(d[2:0]) : int'(d[3:0]);
        acc = 0; c = 0; g = 0; errs = 0;
        for (int i = 0; i < n; i++) begin
            len = m + (((acc + f) >= md) ? 1 : 0);
            c++;
            eo = (c == len);
            eb = 1'b0;
            if (eo) begin
                eb = (g == md - 1);
                c = 0;
                acc = (acc + f) % md;
                g = (g + 1) % md;
            end
            if ((os_tick !== eo) || (bit_tick !== eb)) begin
                if (errs == 0)
                    $display("FAIL R5/R6 div %0h cycle %0d: actual os=%b bit=%b expected os=%b bit=%b",
                             d, i + 1, os_tick, bit_tick, eo, eb);
                errs++;
            end
            @(negedge clk);
        end
        n_chk++;
        if (errs != 0) n_bad++;
    endtask

    task automatic bit_gap(input logic [15:0] d, input int exp_gap, input string tag);
        int k, first;
        do_write(d, 1'b1);
        k = 1; first = -1;
        while (k < 200) begin
            if (bit_tick) begin
                if (first < 0) first = k;
                else break;
            end
            @(negedge clk);
            k++;
        end
        chk(32'(k - first), 32'(exp_gap), tag);
    endtask

    initial begin
        int tk, k;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(32'(os_tick), 0, "R1 os_tick");
        chk(32'(bit_tick), 0, "R1 bit_tick");
        chk(32'(div_bad), 1, "R1 div_bad");
        chk(32'(div_rd), 0, "R1 div_rd");
        rst_n = 1'b1;
        tk = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (os_tick) tk++;
        end
        chk(32'(tk), 0, "R1 no strobe before write");
        chk(32'(ratio), 0, "R1 ratio");

        for (int i = 0; i < 8; i++) begin
            run_seq(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0],
                    3 * int'(VEC[i][15:0]) + 6);
        end

        // R3: zero mantissa halts
        do_write(16'h0005, 1'b0);
        chk(32'(div_bad), 1, "R3 div_bad");
        tk = 0;
        for (int i = 0; i < 40; i++) begin
            if (os_tick) tk++;
            @(negedge clk);
        end
        chk(32'(tk), 0, "R3 no strobe");

        // R7: rewrite mid-period restarts the count
        do_write(16'h0040, 1'b0);
        @(negedge clk);
        do_write(16'h0040, 1'b0);
        chk(32'(div_bad), 0, "R7 div_bad clear");
        k = 1;
        while (!os_tick && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(32'(k), 4, "R7 first strobe after write");

        // R9: top rates in 8x mode
        bit_gap(16'h0010, 8, "R9 bit spacing M=1");
        bit_gap(16'h0020, 16, "R9 bit spacing M=2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule